// File: doc/BRIEF.md
# Immediate Operand Builder

This combinational block turns a 32-bit base-integer instruction word into the 32-bit immediate operand for that instruction. The operand feeds the second-operand multiplexer of the ALU and the adder that forms jump and branch targets. Five immediate layouts are handled: register-immediate (I), store (S), conditional branch (B), upper (U) and jump (J). Each layout scatters its bits differently across the word. The block gathers those bits back into order, inserts the zero low bit that branch and jump offsets leave implicit, and fills the upper bits with the top bit of the field.

The format can come from two sources. A three-bit selector lets an external decoder name the layout. When the auto-decode input is high, the block ignores the selector and finds the layout from the opcode in bits [6:0] of the word. A layout that is not defined, from either source, gives an all-zero operand.

Top module: `imm_extract`

## Requirements
- R1: With layout I, immOut is instWord[31:20] sign-extended. For example, a field of 0xFF8 gives 0xFFFFFFF8, 0x7FF gives 0x000007FF and 0x800 gives 0xFFFFF800.
- R2: With layout S, immOut is {instWord[31:25], instWord[11:7]} sign-extended.
- R3: With layout B, immOut is {instWord[31], instWord[7], instWord[30:25], instWord[11:8], 1'b0} sign-extended. Bit 0 is always zero, and the range runs from -4096 to +4094.
- R4: With layout U, immOut is {instWord[31:12], 12'h000}.
- R5: With layout J, immOut is {instWord[31], instWord[19:12], instWord[20], instWord[30:21], 1'b0} sign-extended. Bit 0 is always zero.
- R6: For layouts I, S, B and J, every bit of immOut above the field equals instWord[31]. No layout is zero-extended.
- R7: With autoDecode=0, fmtSel selects the layout as follows: 0=I, 1=S, 2=B, 3=U, 4=J. The codes 5, 6 and 7 give immOut=0.
- R8: With autoDecode=1, fmtSel has no effect. The layout comes from instWord[6:0] as follows:
  - 0000011, 0010011 and 1100111 select I.
  - 0100011 selects S.
  - 1100011 selects B.
  - 0110111 and 0010111 select U.
  - 1101111 selects J.
- R9: With autoDecode=1, any other opcode, such as 0110011, gives immOut=0.
- R10: With autoDecode=0, the layout follows fmtSel even when the opcode belongs to a different layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instWord | input | 32 | Instruction word |
| fmtSel | input | 3 | Layout selector, used when autoDecode is 0 |
| autoDecode | input | 1 | 1: find the layout from the opcode bits |
| immOut | output | 32 | Reassembled, sign-extended immediate |

## Verification
The two layout sources meet in the same evaluation. When auto-decode is high, the selector still carries a value, and that value may name a different layout or an undefined code. The bench drives words whose opcode names one layout while the selector names another or an undefined one. It then checks that only the active source decides the result: under auto-decode the operand must follow the opcode, and under manual selection it must follow the selector regardless of the opcode.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int INST_W = 32;
  localparam int OPC_W  = 7;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    FMT_I = 3'd0,
    FMT_S = 3'd1,
    FMT_B = 3'd2,
    FMT_U = 3'd3,
    FMT_J = 3'd4
  } fmt_e;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    logic pickI;
    logic pickS;
    logic pickB;
    logic pickU;
    logic pickJ;
  } fmt_strobe_t;
endpackage

// File: rtl/imm_fmt_ctrl.sv
module imm_fmt_ctrl
  import imm_pkg::*;
(
  input  logic [SEL_W-1:0] fmtSel,
  input  logic [OPC_W-1:0] opcode,
  input  logic             autoDecode,
  output fmt_strobe_t      strobe
);
  fmt_strobe_t manualStrobe;
  fmt_strobe_t opcStrobe;

  always_comb begin
    manualStrobe = '0;
    case (fmtSel)
      FMT_I:   manualStrobe.pickI = 1'b1;
      FMT_S:   manualStrobe.pickS = 1'b1;
      FMT_B:   manualStrobe.pickB = 1'b1;
      FMT_U:   manualStrobe.pickU = 1'b1;
      FMT_J:   manualStrobe.pickJ = 1'b1;
      default: manualStrobe = '0;
    endcase
  end

  always_comb begin
    opcStrobe = '0;
    case (opcode)
      OPC_LOAD, OPC_OPIMM, OPC_JALR: opcStrobe.pickI = 1'b1;
      OPC_STORE:                     opcStrobe.pickS = 1'b1;
      OPC_BRANCH:                    opcStrobe.pickB = 1'b1;
      OPC_LUI, OPC_AUIPC:            opcStrobe.pickU = 1'b1;
      OPC_JAL:                       opcStrobe.pickJ = 1'b1;
      default:                       opcStrobe = '0;
    endcase
  end

  assign strobe = autoDecode ? opcStrobe : manualStrobe;

  always_comb begin
    assert_onehot_R7: assert ($onehot0(strobe))
      else $error("format strobe not one-hot");
    if (!autoDecode && fmtSel > SEL_W'(FMT_J))
      assert_undef_sel_R7: assert (strobe == '0)
        else $error("undefined select raised a strobe");
    if (autoDecode && opcode == OPC_STORE)
      assert_store_opc_R8: assert (strobe.pickS)
        else $error("store opcode did not select S layout");
    if (autoDecode && opcode == 7'b0110011)
      assert_regop_R9: assert (strobe == '0)
        else $error("register opcode raised a strobe");
  end
endmodule

// File: rtl/imm_gather_dp.sv
module imm_gather_dp
  import imm_pkg::*;
#(
  parameter int OUT_W = INST_W
) (
  input  logic [INST_W-1:0] instWord,
  input  fmt_strobe_t       strobe,
  output logic [OUT_W-1:0]  immOut
);
  localparam int I_W = 12;
  localparam int S_W = 12;
  localparam int B_W = 13;
  localparam int J_W = 21;
  localparam int U_W = 20;
  localparam int U_LO = OUT_W - U_W;

  logic [I_W-1:0] fieldI;
  logic [S_W-1:0] fieldS;
  logic [B_W-1:0] fieldB;
  logic [J_W-1:0] fieldJ;
  logic [OUT_W-1:0] extI, extS, extB, extJ, extU;

  assign fieldI = instWord[31:20];
  assign fieldS = {instWord[31:25], instWord[11:7]};
  assign fieldB = {instWord[31], instWord[7], instWord[30:25], instWord[11:8], 1'b0};
  assign fieldJ = {instWord[31], instWord[19:12], instWord[20], instWord[30:21], 1'b0};

  assign extI = {{(OUT_W-I_W){fieldI[I_W-1]}}, fieldI};
  assign extS = {{(OUT_W-S_W){fieldS[S_W-1]}}, fieldS};
  assign extB = {{(OUT_W-B_W){fieldB[B_W-1]}}, fieldB};
  assign extJ = {{(OUT_W-J_W){fieldJ[J_W-1]}}, fieldJ};

  generate
    if (U_LO > 0) begin : g_upper_pad
      assign extU = {instWord[31:12], {U_LO{1'b0}}};
    end else begin : g_upper_bare
      assign extU = instWord[31:12];
    end
  endgenerate

  always_comb begin
    immOut = '0;
    unique case (1'b1)
      strobe.pickI: immOut = extI;
      strobe.pickS: immOut = extS;
      strobe.pickB: immOut = extB;
      strobe.pickU: immOut = extU;
      strobe.pickJ: immOut = extJ;
      default:      immOut = '0;
    endcase
  end

  always_comb begin
    if (strobe.pickB || strobe.pickJ)
      assert_even_offset_R3: assert (immOut[0] == 1'b0)
        else $error("branch/jump offset odd");
  end
endmodule

// File: rtl/imm_extract.sv
module imm_extract
  import imm_pkg::*;
(
  input  logic [31:0] instWord,
  input  logic [2:0]  fmtSel,
  input  logic        autoDecode,
  output logic [31:0] immOut
);
  fmt_strobe_t strobe;

  imm_fmt_ctrl u_ctrl (
    .fmtSel     (fmtSel),
    .opcode     (instWord[OPC_W-1:0]),
    .autoDecode (autoDecode),
    .strobe     (strobe)
  );

  imm_gather_dp #(.OUT_W(INST_W)) u_dp (
    .instWord (instWord),
    .strobe   (strobe),
    .immOut   (immOut)
  );

  always_comb begin
    if (strobe.pickI || strobe.pickS || strobe.pickB || strobe.pickJ)
      assert_sign_fill_R6: assert (immOut[31:21] == {11{instWord[31]}})
        else $error("upper bits not sign fill");
    if (strobe.pickU)
      assert_upper_low_R4: assert (immOut[11:0] == 12'h000 && immOut[31:12] == instWord[31:12])
        else $error("upper layout wrong");
    if (strobe == '0)
      assert_none_zero_R7: assert (immOut == 32'h0)
        else $error("no layout but nonzero operand");
  end
endmodule

// File: tb/sim_imm_extract.sv
module sim_imm_extract;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instWord;
  logic [2:0]  fmtSel;
  logic        autoDecode;
  logic [31:0] immOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  imm_extract u0 (
    .instWord   (instWord),
    .fmtSel     (fmtSel),
    .autoDecode (autoDecode),
    .immOut     (immOut)
  );

  typedef struct packed {
    logic [31:0] inst;
    logic [2:0]  sel;
    logic        auto;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{32'hFF800093, 3'd0, 1'b0, 32'hFFFFFFF8, 4'd1},  // R1 0xFF8 -> -8
    '{32'h7FF00013, 3'd0, 1'b0, 32'h000007FF, 4'd1},  // R1 max
    '{32'h80000013, 3'd0, 1'b0, 32'hFFFFF800, 4'd1},  // R1 min
    '{32'hFE002E23, 3'd1, 1'b0, 32'hFFFFFFFC, 4'd2},  // R2 -4
    '{32'h120001A3, 3'd1, 1'b0, 32'h00000123, 4'd2},  // R2 positive
    '{32'h80000063, 3'd2, 1'b0, 32'hFFFFF000, 4'd3},  // R3 -4096
    '{32'h7E000FE3, 3'd2, 1'b0, 32'h00000FFE, 4'd3},  // R3 +4094
    '{32'hABCDE0B7, 3'd3, 1'b0, 32'hABCDE000, 4'd4},  // R4
    '{32'hFFFFFFFF, 3'd3, 1'b0, 32'hFFFFF000, 4'd4},  // R4 low bits zero
    '{32'hFFFFF06F, 3'd4, 1'b0, 32'hFFFFFFFE, 4'd5},  // R5 -2
    '{32'h0010006F, 3'd4, 1'b0, 32'h00000800, 4'd5},  // R5 bit 11 from inst[20]
    '{32'h0001006F, 3'd4, 1'b0, 32'h00010000, 4'd5},  // R5 bit 16 in place
    '{32'hFFFFFFFF, 3'd2, 1'b0, 32'hFFFFFFFE, 4'd6},  // R6 all ones B
    '{32'hFFFFFFFF, 3'd5, 1'b0, 32'h00000000, 4'd7},  // R7 code 5
    '{32'hFFFFFFFF, 3'd7, 1'b0, 32'h00000000, 4'd7},  // R7 code 7
    '{32'hFF800093, 3'd1, 1'b0, 32'hFFFFFFE1, 4'd10}, // R10 S on I word
    '{32'h80000063, 3'd4, 1'b0, 32'hFFF00000, 4'd10}, // R10 J on B word
    '{32'hFF800093, 3'd7, 1'b1, 32'hFFFFFFF8, 4'd8},  // R8 op-imm, sel ignored
    '{32'hFE002E23, 3'd0, 1'b1, 32'hFFFFFFFC, 4'd8},  // R8 store
    '{32'h80000063, 3'd3, 1'b1, 32'hFFFFF000, 4'd8},  // R8 branch
    '{32'h12345037, 3'd0, 1'b1, 32'h12345000, 4'd8},  // R8 lui
    '{32'h00001017, 3'd4, 1'b1, 32'h00001000, 4'd8},  // R8 auipc
    '{32'hFFFFF06F, 3'd1, 1'b1, 32'hFFFFFFFE, 4'd8},  // R8 jal
    '{32'hFFC08067, 3'd6, 1'b1, 32'hFFFFFFFC, 4'd8},  // R8 jalr
    '{32'h80002003, 3'd2, 1'b1, 32'hFFFFF800, 4'd8},  // R8 load
    '{32'hFFFFFFB3, 3'd0, 1'b1, 32'h00000000, 4'd9}   // R9 register opcode
  };

  task automatic check(input logic [31:0] exp, input int req);
    checks++;
    if (immOut !== exp) begin
      fails++;
      $display("FAIL R%0d inst=%h sel=%0d auto=%0b actual=%h expected=%h",
               req, instWord, fmtSel, autoDecode, immOut, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [2:0] s, input logic a);
    @(posedge clk);
    instWord = i; fmtSel = s; autoDecode = a;
    @(negedge clk);
  endtask

  initial begin
    instWord = '0; fmtSel = '0; autoDecode = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: zero word, layout I -> zero operand (R1)
    check(32'h0, 1);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].inst, VECS[k].sel, VECS[k].auto);
      check(VECS[k].exp, int'(VECS[k].req));
    end

    // R8: sweep every select code under auto-decode on one branch word
    for (int s = 0; s < 8; s++) begin
      apply(32'h7E000FE3, 3'(s), 1'b1);
      check(32'h00000FFE, 8);
    end

    // R6: single top bit set, every signed layout fills upward
    apply(32'h80000000, 3'd0, 1'b0); check(32'hFFFFF800, 6);
    apply(32'h80000000, 3'd1, 1'b0); check(32'hFFFFF800, 6);
    apply(32'h80000000, 3'd4, 1'b0); check(32'hFFF00000, 6);

    // R3: bit 7 alone supplies offset bit 11
    apply(32'h00000080, 3'd2, 1'b0); check(32'h00000800, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule